// File: doc/BRIEF.md
# Fan Revolution Period Counter

This block times one full turn of a fan. A tachometer line from the fan is brought into the clock domain, and its rising edges are found. A counter of a fixed 90 kHz timebase runs between them. A fan gives one to four tachometer pulses per turn, and a 2-bit setting says how many. Once that many rising edges have passed, the number of timebase ticks is latched as a 16-bit revolution period. Software turns the period into speed as RPM = 90000 × 60 / period. For example, a period of 6143 gives about 879 RPM.

A fan that has stopped or is missing gives no edges. The counter then stops at its ceiling of 0xFFFF. That value is latched and flagged, so a stall reads as the largest possible period. Software reads the period one byte at a time. Reading the low byte copies the high byte into a shadow register, and the later high-byte read returns that copy. The two bytes therefore always belong to the same measurement.

Top module: `fan_rev_timer`

## Requirements
- R1: After reset the latched period is 0xFFFF, `fan_stalled` is 1, `rd_data` is 0, and the shadow high byte is 0xFF.
- R2: The latched period equals the number of timebase ticks over N rising-edge intervals, where `ppr_code` 00, 01, 10 and 11 select N = 1, 2, 3 and 4.
- R3: The running count stops at 0xFFFF. When it gets there, 0xFFFF is latched as the period and `fan_stalled` is 1. `fan_stalled` is 1 exactly when the latched period is 0xFFFF.
- R4: `tach_in` passes through a two-flop synchronizer, and only its rising edges are counted. The pulse high width and the falling edges do not change the period.
- R5: The edge that completes a window latches the count and also starts the next window from zero. A new window counts the tick of its own starting cycle. Consecutive measurements do not add up.
- R6: A read with `rd_en`=1 and `rd_sel`=0 returns bits [7:0] of the latched period on `rd_data` one cycle later. The same read copies bits [15:8] into the shadow register.
- R7: A read with `rd_en`=1 and `rd_sel`=1 returns the shadow register one cycle later. A period latched after the last low-byte read does not change it.
- R8: The first rising edge after reset, and the first after a saturation, only opens a window. It latches nothing.
- R9: The timebase ticks once every round(CLK_HZ/TICK_HZ) clocks, so the period is counted in timebase ticks and not in clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tach_in | input | 1 | Fan tachometer line, asynchronous to clk |
| ppr_code | input | 2 | Pulses per revolution, N = code + 1 |
| rd_en | input | 1 | Byte read strobe |
| rd_sel | input | 1 | 0 selects the low byte, 1 selects the shadow high byte |
| rd_data | output | 8 | Byte returned one cycle after a read |
| fan_stalled | output | 1 | Latched period is at its ceiling |

## Verification
Steady pulse trains are sent with each of the four pulses-per-revolution codes. A period that comes out as exactly N times the spacing, in ticks, shows that edge grouping, restart and prescaling are all right. Other cases:
- Trains with the same spacing but very different high widths separate rising-edge counting from any sensitivity to level or falling edges.
- A long train, a low-byte read, then a shorter train shows whether the high-byte shadow really holds its value.
- A silent line held past the ceiling, followed by a fresh train, exercises saturation and the re-arming that follows it.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;

    localparam int RES_W = 16;
    localparam logic [RES_W-1:0] CNT_MAX = {RES_W{1'b1}};

    typedef enum logic {
        WIN_IDLE = 1'b0,
        WIN_RUN  = 1'b1
    } win_state_e;

    typedef struct packed {
        win_state_e       st;
        logic [1:0]       edges;
        logic [RES_W-1:0] count;
        logic [RES_W-1:0] result;
    } win_regs_t;

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_regs_t;

    typedef struct packed {
        logic [7:0] shadow;
        logic [7:0] rd_data;
    } rd_regs_t;

    // pulses per revolution: code 00..11 -> 1..4
    function automatic logic [2:0] ppr_to_count(input logic [1:0] code);
        return {1'b0, code} + 3'd1;
    endfunction

endpackage

// File: rtl/tach_tick_gen.sv
module tach_tick_gen #(
    parameter int DIV = 556
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign tick = (cnt_q == LAST);

            // R9: ticks are isolated strobes, never back to back
            p_tick_isolated_r9: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/tach_sync_edge.sv
module tach_sync_edge
    import fan_tach_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tach_in,
    output logic rise
);
    sync_regs_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.s1 = tach_in;
        r_d.s2 = r_q.s1;
        r_d.s3 = r_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rise = r_q.s2 & ~r_q.s3;

    // R4: a rising edge yields a single-cycle strobe
    p_rise_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/rev_window_ctr.sv
module rev_window_ctr
    import fan_tach_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rise,
    input  logic [1:0]       ppr_code,
    output logic [RES_W-1:0] period
);
    win_regs_t r_d, r_q;
    logic [2:0] target;
    logic       last_edge;
    logic       latch_now;

    always_comb begin
        target    = ppr_to_count(ppr_code);
        last_edge = ({1'b0, r_q.edges} + 3'd1) >= target;
        latch_now = 1'b0;
        r_d       = r_q;
        case (r_q.st)
            WIN_IDLE: begin
                if (rise) begin
                    r_d.st    = WIN_RUN;
                    r_d.edges = '0;
                    r_d.count = RES_W'(tick);
                end
            end
            default: begin
                if (r_q.count == CNT_MAX) begin
                    r_d.result = CNT_MAX;
                    r_d.st     = WIN_IDLE;
                    r_d.count  = '0;
                    r_d.edges  = '0;
                end else if (rise && last_edge) begin
                    latch_now  = 1'b1;
                    r_d.result = r_q.count;
                    r_d.edges  = '0;
                    r_d.count  = RES_W'(tick);
                end else begin
                    if (rise) r_d.edges = r_q.edges + 2'd1;
                    r_d.count = r_q.count + RES_W'(tick);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st     <= WIN_IDLE;
            r_q.edges  <= '0;
            r_q.count  <= '0;
            r_q.result <= CNT_MAX;
        end else begin
            r_q <= r_d;
        end
    end

    assign period = r_q.result;

    // R3: a count at its ceiling is reported as the period and the window closes
    p_sat_report_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == WIN_RUN && r_q.count == CNT_MAX) |=> (period == CNT_MAX && r_q.st == WIN_IDLE));
    // R5: the completing edge hands over its count and restarts from zero
    p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        latch_now |=> (period == $past(r_q.count) && r_q.count <= RES_W'(1)));
    // R8: an idle window holds the period until an edge opens a new one
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == WIN_IDLE && !rise) |=> ($stable(period) && r_q.count == '0));
endmodule

// File: rtl/period_byte_port.sv
module period_byte_port
    import fan_tach_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RES_W-1:0] period,
    input  logic             rd_en,
    input  logic             rd_sel,
    output logic [7:0]       rd_data
);
    rd_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (rd_en) begin
            if (!rd_sel) begin
                r_d.rd_data = period[7:0];
                r_d.shadow  = period[15:8];
            end else begin
                r_d.rd_data = r_q.shadow;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.shadow  <= 8'hFF;
            r_q.rd_data <= 8'h00;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_data = r_q.rd_data;

    // R6: a low-byte read returns the period's low byte one cycle later
    p_lo_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_sel) |=> rd_data == $past(period[7:0]));
    // R7: the shadow high byte only moves on a low-byte read
    p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && !rd_sel) |=> $stable(r_q.shadow));
endmodule

// File: rtl/fan_rev_timer.sv
module fan_rev_timer
    import fan_tach_pkg::*;
#(
    parameter int CLK_HZ  = 50_000_000,
    parameter int TICK_HZ = 90_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tach_in,
    input  logic [1:0] ppr_code,
    input  logic       rd_en,
    input  logic       rd_sel,
    output logic [7:0] rd_data,
    output logic       fan_stalled
);
    localparam int DIV = (CLK_HZ + TICK_HZ / 2) / TICK_HZ;

    logic             tick;
    logic             rise;
    logic [RES_W-1:0] period;

    tach_tick_gen #(.DIV(DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    tach_sync_edge u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .tach_in (tach_in),
        .rise    (rise)
    );

    rev_window_ctr u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .rise     (rise),
        .ppr_code (ppr_code),
        .period   (period)
    );

    period_byte_port u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .period  (period),
        .rd_en   (rd_en),
        .rd_sel  (rd_sel),
        .rd_data (rd_data)
    );

    assign fan_stalled = (period == CNT_MAX);

    // R3: the stall flag follows a saturated period
    p_stall_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (u_win.r_q.st == WIN_RUN && u_win.r_q.count == CNT_MAX) |=> fan_stalled);
endmodule

// File: tb/sim_fan_rev_timer.sv
module sim_fan_rev_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tach_in = 1'b0;
    logic [1:0] ppr_code = 2'b01;
    logic       rd_en = 1'b0;
    logic       rd_sel = 1'b0;
    logic [7:0] rd_data;
    logic       fan_stalled;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // tick every 2 clocks
    fan_rev_timer #(.CLK_HZ(180_000), .TICK_HZ(90_000)) u0 (
        .clk(clk), .rst_n(rst_n), .tach_in(tach_in), .ppr_code(ppr_code),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .fan_stalled(fan_stalled)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic read_byte(input logic sel, output logic [7:0] b);
        @(negedge clk);
        rd_en = 1'b1; rd_sel = sel;
        @(negedge clk);
        rd_en = 1'b0;
        b = rd_data;
    endtask

    task automatic read_word(output logic [15:0] w);
        logic [7:0] lo, hi;
        read_byte(1'b0, lo);
        read_byte(1'b1, hi);
        w = {hi, lo};
    endtask

    task automatic send_edges(input int n, input int period, input int hi);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tach_in = 1'b1;
            repeat (hi) @(negedge clk);
            tach_in = 1'b0;
            repeat (period - hi - 1) @(negedge clk);
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [15:0] w;
        check("R1 stall flag", fan_stalled, 1);
        check("R1 rd_data", rd_data, 0);
        read_word(w);
        check("R1 period", w, 16'hFFFF);
    endtask

    task automatic t_first_edge;
        logic [15:0] w;
        send_edges(1, 40, 10);
        read_word(w);
        check("R8 first edge latches nothing", w, 16'hFFFF);
    endtask

    task automatic t_ppr;
        logic [15:0] w;
        for (int c = 0; c < 4; c++) begin
            ppr_code = c[1:0];
            send_edges(3 * (c + 1) + 1, 40, 10);
            read_word(w);
            // R2 R9: N intervals of 40 clocks at 2 clocks per tick
            check($sformatf("R2 ppr code %0d", c), w, (c + 1) * 20);
        end
        check("R3 flag low with valid period", fan_stalled, 0);
    endtask

    task automatic t_rising_only;
        logic [15:0] w;
        ppr_code = 2'b00;
        send_edges(4, 50, 3);
        read_word(w);
        check("R4 narrow pulses", w, 25);
        send_edges(4, 50, 40);
        read_word(w);
        check("R4 wide pulses", w, 25);
    endtask

    task automatic t_coherent;
        logic [7:0] b;
        ppr_code = 2'b00;
        send_edges(3, 2000, 20);
        read_byte(1'b0, b);
        check("R6 low byte", b, 8'hE8);
        send_edges(3, 600, 20);   // period now 300 = 0x012C
        read_byte(1'b1, b);
        check("R7 shadow keeps old high byte", b, 8'h03);
        read_byte(1'b0, b);
        check("R5 R6 new low byte", b, 8'h2C);
        read_byte(1'b1, b);
        check("R7 new high byte after low read", b, 8'h01);
    endtask

    task automatic t_stall;
        logic [15:0] w;
        repeat (131_200) @(negedge clk);
        check("R3 stall flag", fan_stalled, 1);
        read_word(w);
        check("R3 saturated period", w, 16'hFFFF);
        ppr_code = 2'b00;
        send_edges(1, 40, 10);
        read_word(w);
        check("R8 re-arm edge latches nothing", w, 16'hFFFF);
        send_edges(3, 40, 10);
        read_word(w);
        check("R8 recovery period", w, 20);
        check("R3 flag clears", fan_stalled, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_edge();
        t_ppr();
        t_rising_only();
        t_coherent();
        t_stall();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190_000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule